// File: doc/BRIEF.md
# Time-Sliced Weighted Bus Arbiter

This block decides which of four requesters may drive a shared parallel bus. Requester 0 is the bridge's own internal master and requesters 1 to 3 are external bus devices. Bus time is divided into phases. A 128-entry slot table says which requester owns each phase. A slot pointer moves to the next entry on every pulse of a slower isochronous reference tick, not on every bus clock. Because a requester may own several slots, the contents of the table set how much bus time each requester receives.

Software fills the table through a simple address/data write port while arbitration is switched off. After that, the arbiter issues one-hot grants that follow the table. A holder keeps its grant for as long as its request stays high. When the phase moves to a different owner, the behaviour depends on the mode:

- In passive mode, the holder is allowed to finish its transfer.
- In aggressive mode, the holder's grant is taken away and it receives a one-cycle stop pulse. It then has to wait for a phase it owns before it is granted again.

Top module: `phase_port_arbiter`

## Requirements
- R1: After a synchronous active-low reset, `grant` is all zero, `stop` is low, the slot pointer is at slot 0 and every table entry holds 0.
- R2: A table entry value k (0 to 3) names requester k, whose grant is bit k of `grant`. A write with `tbl_wr_en` high stores `tbl_wr_data` at `tbl_wr_addr` only while `arb_en` is low. A write while `arb_en` is high leaves the table unchanged.
- R3: While `arb_en` is high, each cycle with `slot_tick` high moves the pointer one slot forward, and slot 127 is followed by slot 0. While `arb_en` is low, the pointer returns to slot 0 and stays there.
- R4: When no grant is active, `arb_en` is high and the current slot's owner is requesting, the following cycle shows exactly that owner's grant bit.
- R5: When no grant is active and the current owner is not requesting, no grant is issued, even if other requesters are requesting.
- R6: A holder keeps its grant while its request stays high, unless R8 applies. The grant clears in the cycle after its request drops, with `stop` low.
- R7: With `aggr_mode` low, a holder that still requests keeps its grant after the phase moves to another owner.
- R8: With `aggr_mode` high, a requesting holder that is no longer the current owner loses its grant in the next cycle. In that same cycle `stop` is high, and `stop` stays high for exactly one cycle.
- R9: A requester that was stopped is granted again only from a slot it owns.
- R10: At most one grant bit is high at any time. Grants clear in the cycle after `arb_en` is low, without a stop pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arb_en | input | 1 | Arbitration enable; table writes are accepted only while low |
| aggr_mode | input | 1 | 1 = preempt a holder on an owner change, 0 = let it finish |
| slot_tick | input | 1 | Isochronous reference tick, one bus clock wide |
| req | input | 4 | Request lines, bit k for requester k |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | 7 | Slot index to write |
| tbl_wr_data | input | 2 | Owner number to store |
| grant | output | 4 | One-hot grant, bit k for requester k |
| stop | output | 1 | One-cycle stop pulse to a preempted holder |

## Verification
The bench targets the following corner cases, each with the failure a wrong design would show:

- **Owner change in both modes.** A holder must be cut off with a single stop pulse in aggressive mode and kept in passive mode. A design that confused the two would either drop transfers or stretch them across foreign phases.
- **Idle phase owner.** The bench gives the slot to a non-requesting owner while others are requesting. A design that gave the slot away would grant a bystander.
- **Table wrap.** The pointer is driven past slot 127. A design that wrapped wrongly would grant the owner of a slot that does not exist.
- **Writes during arbitration.** A write issued while `arb_en` is high must have no effect. A design that accepted it would change grants.
- **Release and preemption together.** The bench drops the holder's request in the same cycle as an owner change. A design that pulsed `stop` there would signal a stop to a master that had already finished.

// File: rtl/phase_arb_pkg.sv
// Shared types of the time-sliced arbiter.
// Assumes nothing beyond a SystemVerilog-2017 compiler.
package phase_arb_pkg;

    // Per-cycle decision of the grant controller.
    typedef enum logic [2:0] {
        DEC_IDLE    = 3'd0,  // nothing granted, nothing to grant
        DEC_GRANT   = 3'd1,  // bus idle, phase owner requests
        DEC_KEEP    = 3'd2,  // holder continues its transfer
        DEC_RELEASE = 3'd3,  // holder dropped its request
        DEC_PREEMPT = 3'd4   // holder cut off by a new owner
    } arb_dec_e;

endpackage

// File: rtl/slot_table.sv
// Slot table and phase pointer.
// Holds one owner number per slot, writable only while arbitration is off.
// The pointer steps one slot per reference tick and wraps at SLOTS-1.
// Assumes slot_tick is synchronous to clk and one cycle wide per tick.
module slot_table #(
    parameter int unsigned SLOTS  = 128,
    parameter int unsigned PORTS  = 4,
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned ID_W   = $clog2(PORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arb_en,
    input  logic              slot_tick,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_addr,
    input  logic [ID_W-1:0]   wr_data,
    output logic [ID_W-1:0]   owner
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic [ID_W-1:0]   tab [SLOTS];
    logic [SLOT_W-1:0] ptr;

    // Table storage: cleared on reset, written only while arbitration is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                tab[i] <= '0;
            end
        end else if (wr_en && !arb_en) begin
            tab[wr_addr] <= wr_data;
        end
    end

    // Phase pointer: parked at slot 0 when disabled, steps per tick otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !arb_en) begin
            ptr <= '0;
        end else if (slot_tick) begin
            ptr <= (ptr == LAST_SLOT) ? '0 : ptr + 1'b1;
        end
    end

    // Owner of the current phase.
    assign owner = tab[ptr];

    // R3: one step per tick, wrapping after the last slot.
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && slot_tick) |=>
            (ptr == (($past(ptr) == LAST_SLOT) ? '0 : $past(ptr) + 1'b1)));

    // R3: no tick, no movement.
    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && !slot_tick) |=> $stable(ptr));

    // R3: disabled arbitration parks the pointer.
    p_ptr_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_en |=> (ptr == '0));

endmodule

// File: rtl/grant_ctrl.sv
// Grant controller.
// Grants the phase owner only from an idle bus. A holder keeps the bus
// while requesting. In aggressive mode a holder that no longer owns the
// phase is cut off with a one-cycle stop pulse.
// Assumes owner is a registered-table read, stable between clock edges.
module grant_ctrl
    import phase_arb_pkg::*;
#(
    parameter int unsigned PORTS = 4,
    localparam int unsigned ID_W = $clog2(PORTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arb_en,
    input  logic             aggr_mode,
    input  logic [PORTS-1:0] req,
    input  logic [ID_W-1:0]  owner,
    output logic [PORTS-1:0] grant,
    output logic             stop
);

    logic            hold_vld;
    logic [ID_W-1:0] hold_id;
    arb_dec_e        dec;

    // Decide what the bus does in the next cycle.
    always_comb begin
        dec = DEC_IDLE;
        if (arb_en) begin
            if (hold_vld) begin
                if (!req[hold_id]) begin
                    dec = DEC_RELEASE;
                end else if (aggr_mode && (hold_id != owner)) begin
                    dec = DEC_PREEMPT;
                end else begin
                    dec = DEC_KEEP;
                end
            end else if (req[owner]) begin
                dec = DEC_GRANT;
            end
        end
    end

    // Holder register and stop pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld <= 1'b0;
            hold_id  <= '0;
            stop     <= 1'b0;
        end else begin
            stop <= (dec == DEC_PREEMPT);
            unique case (dec)
                DEC_GRANT: begin
                    hold_vld <= 1'b1;
                    hold_id  <= owner;
                end
                DEC_KEEP: hold_vld <= 1'b1;
                default:  hold_vld <= 1'b0;
            endcase
        end
    end

    // One-hot decode of the holder.
    always_comb begin
        grant = '0;
        if (hold_vld) begin
            grant[hold_id] = 1'b1;
        end
    end

    // R10: never more than one grant.
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R10: disabled arbitration clears grants without a stop.
    p_off_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_en |=> (grant == '0 && !stop));

    // R4: an idle bus goes to a requesting owner.
    p_owner_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && grant == '0 && req[owner]) |=>
            ($countones(grant) == 1 && grant[$past(owner)]));

    // R5: a silent owner keeps the slot empty.
    p_no_steal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && !req[owner]) |=> (grant == '0));

    // R7: passive mode keeps a requesting holder.
    p_passive_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && !aggr_mode && (grant & req) != '0) |=> (grant == $past(grant)));

    // R8: the stop pulse lasts one cycle.
    p_stop_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !stop);

    // R8: stop only goes with a grant that was just removed.
    p_stop_cut_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> (grant == '0 && $past(grant) != '0));

endmodule

// File: rtl/phase_port_arbiter.sv
// Top of the time-sliced weighted bus arbiter.
// Connects the slot table to the grant controller.
// Assumes all inputs are synchronous to clk.
module phase_port_arbiter #(
    parameter int unsigned SLOTS  = 128,
    parameter int unsigned PORTS  = 4,
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned ID_W   = $clog2(PORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arb_en,
    input  logic              aggr_mode,
    input  logic              slot_tick,
    input  logic [PORTS-1:0]  req,
    input  logic              tbl_wr_en,
    input  logic [SLOT_W-1:0] tbl_wr_addr,
    input  logic [ID_W-1:0]   tbl_wr_data,
    output logic [PORTS-1:0]  grant,
    output logic              stop
);

    logic [ID_W-1:0] owner;

    slot_table #(.SLOTS(SLOTS), .PORTS(PORTS)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .arb_en    (arb_en),
        .slot_tick (slot_tick),
        .wr_en     (tbl_wr_en),
        .wr_addr   (tbl_wr_addr),
        .wr_data   (tbl_wr_data),
        .owner     (owner)
    );

    grant_ctrl #(.PORTS(PORTS)) u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .arb_en    (arb_en),
        .aggr_mode (aggr_mode),
        .req       (req),
        .owner     (owner),
        .grant     (grant),
        .stop      (stop)
    );

endmodule

// File: tb/phase_port_arbiter_test.sv
`timescale 1ns/1ps
// Self-checking bench: a requirement-level model predicts grant and stop
// for each cycle under directed and seeded random stimulus.
module phase_port_arbiter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, aggr = 1'b0, tick = 1'b0;
    logic [3:0] req = '0;
    logic       wr_en = 1'b0;
    logic [6:0] wr_addr = '0;
    logic [1:0] wr_data = '0;
    logic [3:0] grant;
    logic       stop;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Model state.
    logic [1:0] m_tab [128];
    logic [6:0] m_ptr;
    logic       m_vld;
    logic [1:0] m_id;

    always #2.5 clk = ~clk;

    phase_port_arbiter uut (
        .clk(clk), .rst_n(rst_n), .arb_en(en), .aggr_mode(aggr),
        .slot_tick(tick), .req(req), .tbl_wr_en(wr_en),
        .tbl_wr_addr(wr_addr), .tbl_wr_data(wr_data),
        .grant(grant), .stop(stop)
    );

    // Predict one cycle, clock it, compare.
    task automatic step(input string tag);
        logic [1:0] own;
        logic       nv, ns;
        logic [1:0] nid;
        logic [6:0] np;
        logic [3:0] exp_g;
        own = m_tab[m_ptr];
        nv = m_vld; nid = m_id; ns = 1'b0;
        if (!en) nv = 1'b0;
        else if (m_vld) begin
            if (!req[m_id]) nv = 1'b0;
            else if (aggr && m_id != own) begin nv = 1'b0; ns = 1'b1; end
        end else if (req[own]) begin
            nv = 1'b1; nid = own;
        end
        np = !en ? 7'd0 : (tick ? m_ptr + 7'd1 : m_ptr);
        if (wr_en && !en) m_tab[wr_addr] = wr_data;
        @(posedge clk); #1;
        m_vld = nv; m_id = nid; m_ptr = np;
        exp_g = nv ? (4'b0001 << nid) : 4'b0000;
        checks++;
        if (grant !== exp_g || stop !== ns) begin
            fails++;
            $display("FAIL %s: grant=%b stop=%b expected grant=%b stop=%b",
                     tag, grant, stop, exp_g, ns);
        end
        checks++;
        if ($countones(grant) > 1) begin
            fails++;
            $display("FAIL R10: grant=%b expected at most one bit", grant);
        end
    endtask

    task automatic write_slot(input int a, input int d);
        en = 1'b0; wr_en = 1'b1;
        wr_addr = 7'(a); wr_data = 2'(d);
        step("R2");
        wr_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20251));
        for (int i = 0; i < 128; i++) m_tab[i] = '0;
        m_ptr = '0; m_vld = 1'b0; m_id = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, then an empty table gives slot ownership to 0.
        step("R1");
        en = 1'b1; req = 4'b1111;
        step("R1");
        step("R1");
        req = 4'b0000;
        step("R1");

        // R2: a write while enabled must not change slot 0's owner.
        wr_en = 1'b1; wr_addr = 7'd0; wr_data = 2'd3; req = 4'b1000;
        step("R2");
        wr_en = 1'b0;
        repeat (3) step("R2");

        // Directed owners: slot0=1, slot1=2, slot2=3 (idle), slot3=1.
        write_slot(0, 1); write_slot(1, 2); write_slot(2, 3); write_slot(3, 1);

        // R8 and R9: aggressive preemption of requester 1 by requester 2.
        aggr = 1'b1; en = 1'b1; req = 4'b0110;
        step("R4"); step("R6");
        tick = 1'b1; step("R3"); tick = 1'b0;
        step("R8"); step("R8"); step("R9");
        // R5: slot 2 owner 3 silent while 1 and 2 request.
        tick = 1'b1; step("R3"); tick = 1'b0;
        step("R5"); step("R5"); step("R5");
        tick = 1'b1; step("R3"); tick = 1'b0;
        step("R9"); step("R9");

        // R7: passive mode keeps the holder across an owner change.
        en = 1'b0; step("R10"); step("R10");
        aggr = 1'b0; en = 1'b1; req = 4'b0110;
        step("R4"); step("R7");
        tick = 1'b1; step("R7"); tick = 1'b0;
        repeat (3) step("R7");
        req = 4'b0100; step("R6"); step("R4"); step("R6");

        // Release and owner change together: no stop.
        en = 1'b0; step("R10");
        aggr = 1'b1; en = 1'b1; req = 4'b0110;
        step("R4"); step("R6");
        tick = 1'b1; req = 4'b0100; step("R8"); tick = 1'b0;
        step("R6"); step("R4");

        // R3: wrap past slot 127 with slot 127 owned by 3.
        en = 1'b0; step("R10");
        write_slot(127, 3);
        en = 1'b1; aggr = 1'b1; req = 4'b1111; tick = 1'b1;
        for (int i = 0; i < 140; i++) step("R3");
        tick = 1'b0;

        // Seeded random mix of every control.
        for (int i = 0; i < 6000; i++) begin
            if ((i % 400) == 0) aggr = $urandom_range(1);
            if ((i % 300) < 15) en = 1'b0; else en = 1'b1;
            tick = ($urandom_range(3) == 0);
            for (int b = 0; b < 4; b++)
                if ($urandom_range(7) == 0) req[b] = ~req[b];
            wr_en = ($urandom_range(3) == 0);
            wr_addr = 7'($urandom_range(127));
            wr_data = 2'($urandom_range(3));
            step(aggr ? "R8" : "R7");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        #(5 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule